// File: doc/BRIEF.md
# Data Access Translation Checker

This block decides, for one data memory access, whether the access may proceed and where it goes. It receives the virtual address, a write flag, an 8-bit selector code with its class already decoded into separate flags, and the processor state bits: trap level above zero, privileged, hypervisor, address mask and data translation enable. It also receives the result of a TLB lookup made in the same cycle. It drives the lookup key (context and real flag) back to the TLB without a register, so that the array can answer within the request cycle.

One cycle after a request, the block pulses either `done` or `fault`. With `done` it also gives a physical address and an uncacheable flag. With `fault` it gives a small fault code. The checks run in a fixed order, and the first one that fails decides the result:

1. selector privilege
2. alignment
3. address hole
4. scratch and MMU register selectors
5. hypervisor bypass
6. TLB miss
7. write protection
8. no-fault page
9. page privilege

Most faults also update a fault status register and a fault address register. A miss updates only a tag-access register.

Top module: `dxc_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, `fault`, `fsr`, `far_va` and `tag_acc` become 0.
- R2: A request sampled at an edge gives exactly one pulse of `done` or `fault` in the following cycle. A cycle with no request gives neither.
- R3: Context type and lookup context:
  - With `st_tl_nz` set, the context type is nucleus (2) and the lookup context is 0.
  - Otherwise, a non-implicit access with a secondary selector uses `ctx_sec` with type 1.
  - Every other access uses `ctx_pri` with type 0.
  - The access is real when translation is disabled outside hypervisor mode, or when a non-implicit selector is of the real type. A real access drives `lk_real`=1 and a lookup context of 0.
- R4: Selector privilege checks apply only to a non-implicit access outside hypervisor mode:
  - Not privileged with a selector that is not an unprivileged type gives fault code 1.
  - Privileged with a hypervisor-only selector gives fault code 2.
  - In both cases the status context type is nucleus and the fault type is 4.
- R5: Alignment faults give code 3 with fault type 1 and the status write bit cleared. They occur when `req_va[2:0]` is nonzero, or when a block selector has nonzero `req_va[5:0]`.
- R6: With `st_amask` set, the address is cut to its low 32 bits and no hole check is made. Otherwise, an address whose bits 63:47 are neither all zero nor all one gives code 2, fault type 5, side-effect status bit 1 and write bit 0.
- R7: In hypervisor mode, an implicit access, or one whose selector is neither real nor as-if-user, completes with `pa` equal to the low 40 bits of `req_va` and the uncacheable flag clear. The TLB result is ignored.
- R8: On a TLB miss:
  - The fault code is 4 for a real access and 5 otherwise.
  - `tag_acc` becomes the masked address with bits 12:0 replaced by the lookup context.
  - `fsr` and `far_va` are unchanged.
- R9: After a hit, the faults are decided in this order. A write to a non-writable page gives code 6 with fault type 1. Then a no-fault page without a no-fault selector gives code 2 with fault type 3. Then a privileged page while not privileged gives code 2 with fault type 2. In each case the status side-effect bit is the page's side-effect bit. A side-effect page that completes raises `uncache`.
- R10: A completed hit gives `pa` = (`tlb_ppage` AND NOT `tlb_off_mask`) OR (`req_va` AND `tlb_off_mask`).
- R11: Every fault other than a miss rewrites `fsr` as follows. `far_va` takes the faulting address (the masked address for R6, R12 and R9, the raw address otherwise).

  | Bits | Content |
  |------|---------|
  | 0 | 1 |
  | 1 | previous bit 0 |
  | 2 | write flag |
  | 5:4 | context type |
  | 6 | side-effect |
  | 10:7 | fault type |
  | 23:16 | selector code |
  | 3, 15:11 | 0 |

- R12: A non-implicit scratch selector faults with code 2, fault type 4, side-effect 1 and context type 0 in two cases: the masked offset is above 0x38, or it lies in 0x20..0x2F outside hypervisor mode. Otherwise the access completes with `pa` equal to the low 40 bits of `req_va`.
- R13: A non-implicit MMU-register selector that passes the earlier checks completes with `pa` equal to the low 40 bits of `req_va`, without using the TLB result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Request valid |
| req_va | input | 64 | Virtual address |
| req_wr | input | 1 | Access is a write |
| sel_code | input | 8 | Selector code, recorded in status |
| sel_implicit | input | 1 | Implicit selector |
| sel_unpriv | input | 1 | Selector usable unprivileged |
| sel_hyponly | input | 1 | Selector restricted to hypervisor |
| sel_second | input | 1 | Secondary-context selector |
| sel_block | input | 1 | Block-transfer selector |
| sel_nofault | input | 1 | No-fault selector |
| sel_real | input | 1 | Real-address selector |
| sel_asuser | input | 1 | As-if-user selector |
| sel_mmureg | input | 1 | MMU register selector |
| sel_scratch | input | 1 | Scratch register selector |
| st_tl_nz | input | 1 | Trap level above zero |
| st_priv | input | 1 | Privileged mode |
| st_hyp | input | 1 | Hypervisor mode |
| st_amask | input | 1 | 32-bit address mask |
| st_dmmu_en | input | 1 | Data translation enabled |
| ctx_pri | input | 13 | Primary context |
| ctx_sec | input | 13 | Secondary context |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppage | input | 40 | Entry physical page address |
| tlb_off_mask | input | 40 | In-page offset mask of the entry |
| tlb_writable | input | 1 | Page writable |
| tlb_nofault | input | 1 | Page is no-fault only |
| tlb_side | input | 1 | Page has side effects |
| tlb_priv | input | 1 | Page is privileged |
| lk_ctx | output | 13 | Lookup context to TLB |
| lk_real | output | 1 | Lookup is real |
| done | output | 1 | Access completed |
| fault | output | 1 | Access faulted |
| fault_code | output | 3 | Fault code |
| pa | output | 40 | Physical address |
| uncache | output | 1 | Access uncacheable |
| fsr | output | 24 | Fault status register |
| far_va | output | 64 | Fault address register |
| tag_acc | output | 64 | Tag-access register |

## Verification
On every cycle, the assertions check the single-pulse response, the sticky overwrite bit of the status register, and that misses leave the status untouched while they alone move the tag-access register. They also check that the uncacheable flag appears only with completion. The priority order between competing faults can only be seen in the bench's scenarios, where several checks fail at once. The same holds for the context choice, the hole and mask interplay, the scratch offset windows, and the exact physical address bits.

// File: rtl/dxc_pkg.sv
// Package: shared widths, fault codes, context and fault type encodings.
package dxc_pkg;
    typedef enum logic [2:0] {
        FC_NONE      = 3'd0,
        FC_PRIV_ACT  = 3'd1,
        FC_ACC_EXC   = 3'd2,
        FC_ALIGN     = 3'd3,
        FC_REAL_MISS = 3'd4,
        FC_MMU_MISS  = 3'd5,
        FC_PROT      = 3'd6
    } fcode_e;

    typedef enum logic [1:0] {
        CT_PRI = 2'd0,
        CT_SEC = 2'd1,
        CT_NUC = 2'd2
    } ctype_e;

    typedef enum logic [3:0] {
        FT_NONE    = 4'd0,
        FT_OTHER   = 4'd1,
        FT_PRIV    = 4'd2,
        FT_NFO     = 4'd3,
        FT_ILL_SEL = 4'd4,
        FT_RANGE   = 4'd5
    } ftype_e;
endpackage

// File: rtl/dxc_ctx_sel.sv
// Context selection: picks context type and lookup context, decides whether
// the access is real. Assumes selector flags are meaningless when implicit.
module dxc_ctx_sel #(
    parameter int CTX_W = 13
) (
    input  logic              tl_nz,
    input  logic              implicit,
    input  logic              second,
    input  logic              sel_real,
    input  logic              dmmu_en,
    input  logic              hyp,
    input  logic [CTX_W-1:0]  ctx_pri,
    input  logic [CTX_W-1:0]  ctx_sec,
    output dxc_pkg::ctype_e   ct,
    output logic [CTX_W-1:0]  ctx,
    output logic              is_real
);
    import dxc_pkg::*;

    logic [CTX_W-1:0] ctx_raw;

    // Choose context type and raw context from trap level and selector class.
    always_comb begin
        if (tl_nz) begin
            ct      = CT_NUC;
            ctx_raw = '0;
        end else if (!implicit && second) begin
            ct      = CT_SEC;
            ctx_raw = ctx_sec;
        end else begin
            ct      = CT_PRI;
            ctx_raw = ctx_pri;
        end
    end

    // Real access forces context zero.
    always_comb begin
        is_real = (!dmmu_en && !hyp) || (!implicit && sel_real);
        ctx     = is_real ? '0 : ctx_raw;
    end
endmodule

// File: rtl/dxc_pre_chk.sv
// Pre-lookup checks in priority order: selector privilege, alignment,
// address hole, scratch offsets; also flags register selectors that pass.
// Assumes the hole spans VA bits above IMPL_VA_W-1 that are not sign copies.
module dxc_pre_chk #(
    parameter int VA_W      = 64,
    parameter int IMPL_VA_W = 48,
    parameter int MASK_W    = 32
) (
    input  logic              implicit,
    input  logic              unpriv,
    input  logic              hyponly,
    input  logic              block,
    input  logic              mmureg,
    input  logic              scratch,
    input  logic              priv,
    input  logic              hyp,
    input  logic              amask,
    input  logic              wr,
    input  logic [VA_W-1:0]   va,
    input  dxc_pkg::ctype_e   ct_in,
    output logic              flt,
    output dxc_pkg::fcode_e   code,
    output dxc_pkg::ftype_e   ft,
    output logic              se,
    output logic              wr_bit,
    output dxc_pkg::ctype_e   ct_out,
    output logic [VA_W-1:0]   far_nx,
    output logic [VA_W-1:0]   va_eff,
    output logic              reg_pass
);
    import dxc_pkg::*;

    localparam int TOP_W = VA_W - IMPL_VA_W + 1;

    logic [TOP_W-1:0] top_bits;
    logic             in_hole;
    logic             sel_chk;
    logic             mis_al;
    logic             scr_bad;

    // Derive masked address and the individual check conditions.
    always_comb begin
        va_eff   = amask ? {{(VA_W-MASK_W){1'b0}}, va[MASK_W-1:0]} : va;
        top_bits = va[VA_W-1:IMPL_VA_W-1];
        in_hole  = !(&top_bits) && (|top_bits);
        sel_chk  = !implicit && !hyp;
        mis_al   = (va[2:0] != 3'd0) || (block && (va[5:0] != 6'd0));
        scr_bad  = (va_eff > VA_W'(64'h38)) ||
                   (va_eff >= VA_W'(64'h20) && va_eff < VA_W'(64'h30) && !hyp);
    end

    // Priority chain: first failing check decides the fault.
    always_comb begin
        flt      = 1'b0;
        code     = FC_NONE;
        ft       = FT_NONE;
        se       = 1'b0;
        wr_bit   = wr;
        ct_out   = ct_in;
        far_nx   = va;
        reg_pass = 1'b0;
        if (sel_chk && !priv && !unpriv) begin
            flt    = 1'b1;
            code   = FC_PRIV_ACT;
            ft     = FT_ILL_SEL;
            ct_out = CT_NUC;
        end else if (sel_chk && priv && hyponly) begin
            flt    = 1'b1;
            code   = FC_ACC_EXC;
            ft     = FT_ILL_SEL;
            ct_out = CT_NUC;
        end else if (mis_al) begin
            flt    = 1'b1;
            code   = FC_ALIGN;
            ft     = FT_OTHER;
            wr_bit = 1'b0;
        end else if (!amask && in_hole) begin
            flt    = 1'b1;
            code   = FC_ACC_EXC;
            ft     = FT_RANGE;
            se     = 1'b1;
            wr_bit = 1'b0;
            far_nx = va_eff;
        end else if (!implicit && scratch && scr_bad) begin
            flt    = 1'b1;
            code   = FC_ACC_EXC;
            ft     = FT_ILL_SEL;
            se     = 1'b1;
            ct_out = CT_PRI;
            far_nx = va_eff;
        end else if (!implicit && (mmureg || scratch)) begin
            reg_pass = 1'b1;
        end
    end
endmodule

// File: rtl/dxc_post_chk.sv
// Post-hit checks in priority order: write protection, no-fault page,
// page privilege; forms the physical address from page and offset mask.
module dxc_post_chk #(
    parameter int VA_W = 64,
    parameter int PA_W = 40
) (
    input  logic              wr,
    input  logic              sel_nofault,
    input  logic              priv,
    input  logic              pg_wr,
    input  logic              pg_nf,
    input  logic              pg_side,
    input  logic              pg_priv,
    input  logic [PA_W-1:0]   ppage,
    input  logic [PA_W-1:0]   off_mask,
    input  logic [VA_W-1:0]   va,
    output logic              flt,
    output dxc_pkg::fcode_e   code,
    output dxc_pkg::ftype_e   ft,
    output logic [PA_W-1:0]   pa
);
    import dxc_pkg::*;

    // Ordered page permission checks.
    always_comb begin
        flt  = 1'b1;
        code = FC_ACC_EXC;
        ft   = FT_NONE;
        if (wr && !pg_wr) begin
            code = FC_PROT;
            ft   = FT_OTHER;
        end else if (pg_nf && !sel_nofault) begin
            ft = FT_NFO;
        end else if (!priv && pg_priv) begin
            ft = FT_PRIV;
        end else begin
            flt  = 1'b0;
            code = FC_NONE;
        end
    end

    // Page frame bits from the entry, offset bits from the virtual address.
    always_comb begin
        pa = (ppage & ~off_mask) | (va[PA_W-1:0] & off_mask);
    end
endmodule

// File: rtl/dxc_top.sv
// Data access translation checker: sequences pre-lookup checks, hypervisor
// bypass, TLB miss handling and post-hit checks; registers the result one
// cycle after a request and maintains status, address and tag registers.
// Assumes the TLB answers combinationally to lk_ctx/lk_real in the same cycle.
module dxc_top #(
    parameter int VA_W      = 64,
    parameter int PA_W      = 40,
    parameter int CTX_W     = 13,
    parameter int PAGE_W    = 13,
    parameter int IMPL_VA_W = 48,
    parameter int SEL_W     = 8,
    parameter int FSR_W     = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_wr,
    input  logic [SEL_W-1:0]  sel_code,
    input  logic              sel_implicit,
    input  logic              sel_unpriv,
    input  logic              sel_hyponly,
    input  logic              sel_second,
    input  logic              sel_block,
    input  logic              sel_nofault,
    input  logic              sel_real,
    input  logic              sel_asuser,
    input  logic              sel_mmureg,
    input  logic              sel_scratch,
    input  logic              st_tl_nz,
    input  logic              st_priv,
    input  logic              st_hyp,
    input  logic              st_amask,
    input  logic              st_dmmu_en,
    input  logic [CTX_W-1:0]  ctx_pri,
    input  logic [CTX_W-1:0]  ctx_sec,
    input  logic              tlb_hit,
    input  logic [PA_W-1:0]   tlb_ppage,
    input  logic [PA_W-1:0]   tlb_off_mask,
    input  logic              tlb_writable,
    input  logic              tlb_nofault,
    input  logic              tlb_side,
    input  logic              tlb_priv,
    output logic [CTX_W-1:0]  lk_ctx,
    output logic              lk_real,
    output logic              done,
    output logic              fault,
    output logic [2:0]        fault_code,
    output logic [PA_W-1:0]   pa,
    output logic              uncache,
    output logic [FSR_W-1:0]  fsr,
    output logic [VA_W-1:0]   far_va,
    output logic [VA_W-1:0]   tag_acc
);
    import dxc_pkg::*;

    localparam int GAP_W = FSR_W - SEL_W - 11;

    ctype_e           ct_sel;
    logic             is_real;
    logic             pre_flt;
    fcode_e           pre_code;
    ftype_e           pre_ft;
    logic             pre_se;
    logic             pre_wr;
    ctype_e           pre_ct;
    logic [VA_W-1:0]  pre_far;
    logic [VA_W-1:0]  va_eff;
    logic             reg_pass;
    logic             post_flt;
    fcode_e           post_code;
    ftype_e           post_ft;
    logic [PA_W-1:0]  hit_pa;

    logic             n_done;
    logic             n_fault;
    fcode_e           n_code;
    logic [PA_W-1:0]  n_pa;
    logic             n_uc;
    logic             n_fsr_we;
    ftype_e           n_ft;
    logic             n_se;
    logic             n_wr;
    ctype_e           n_ct;
    logic [VA_W-1:0]  n_far;
    logic             n_tag_we;
    logic             bypass;

    fcode_e           code_q;

    dxc_ctx_sel #(.CTX_W(CTX_W)) u_ctx (
        .tl_nz    (st_tl_nz),
        .implicit (sel_implicit),
        .second   (sel_second),
        .sel_real (sel_real),
        .dmmu_en  (st_dmmu_en),
        .hyp      (st_hyp),
        .ctx_pri  (ctx_pri),
        .ctx_sec  (ctx_sec),
        .ct       (ct_sel),
        .ctx      (lk_ctx),
        .is_real  (is_real)
    );

    dxc_pre_chk #(.VA_W(VA_W), .IMPL_VA_W(IMPL_VA_W), .MASK_W(32)) u_pre (
        .implicit (sel_implicit),
        .unpriv   (sel_unpriv),
        .hyponly  (sel_hyponly),
        .block    (sel_block),
        .mmureg   (sel_mmureg),
        .scratch  (sel_scratch),
        .priv     (st_priv),
        .hyp      (st_hyp),
        .amask    (st_amask),
        .wr       (req_wr),
        .va       (req_va),
        .ct_in    (ct_sel),
        .flt      (pre_flt),
        .code     (pre_code),
        .ft       (pre_ft),
        .se       (pre_se),
        .wr_bit   (pre_wr),
        .ct_out   (pre_ct),
        .far_nx   (pre_far),
        .va_eff   (va_eff),
        .reg_pass (reg_pass)
    );

    dxc_post_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_post (
        .wr          (req_wr),
        .sel_nofault (sel_nofault && !sel_implicit),
        .priv        (st_priv),
        .pg_wr       (tlb_writable),
        .pg_nf       (tlb_nofault),
        .pg_side     (tlb_side),
        .pg_priv     (tlb_priv),
        .ppage       (tlb_ppage),
        .off_mask    (tlb_off_mask),
        .va          (req_va),
        .flt         (post_flt),
        .code        (post_code),
        .ft          (post_ft),
        .pa          (hit_pa)
    );

    assign lk_real = is_real;

    // Merge the stages into one next-state decision.
    always_comb begin
        bypass   = st_hyp && (sel_implicit || (!sel_asuser && !sel_real));
        n_done   = 1'b0;
        n_fault  = 1'b0;
        n_code   = FC_NONE;
        n_pa     = req_va[PA_W-1:0];
        n_uc     = 1'b0;
        n_fsr_we = 1'b0;
        n_ft     = pre_ft;
        n_se     = pre_se;
        n_wr     = pre_wr;
        n_ct     = pre_ct;
        n_far    = pre_far;
        n_tag_we = 1'b0;
        if (pre_flt) begin
            n_fault  = 1'b1;
            n_code   = pre_code;
            n_fsr_we = 1'b1;
        end else if (reg_pass || bypass) begin
            n_done = 1'b1;
        end else if (!tlb_hit) begin
            n_fault  = 1'b1;
            n_code   = is_real ? FC_REAL_MISS : FC_MMU_MISS;
            n_tag_we = 1'b1;
        end else if (post_flt) begin
            n_fault  = 1'b1;
            n_code   = post_code;
            n_fsr_we = 1'b1;
            n_ft     = post_ft;
            n_se     = tlb_side;
            n_wr     = req_wr;
            n_ct     = ct_sel;
            n_far    = va_eff;
        end else begin
            n_done = 1'b1;
            n_pa   = hit_pa;
            n_uc   = tlb_side;
        end
    end

    // Result pulses and physical address, registered one cycle after request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            fault   <= 1'b0;
            code_q  <= FC_NONE;
            pa      <= '0;
            uncache <= 1'b0;
        end else begin
            done    <= req_vld && n_done;
            fault   <= req_vld && n_fault;
            uncache <= req_vld && n_uc;
            if (req_vld) begin
                code_q <= n_code;
                pa     <= n_pa;
            end
        end
    end

    // Fault status and fault address update with sticky overwrite bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr    <= '0;
            far_va <= '0;
        end else if (req_vld && n_fsr_we) begin
            fsr    <= {sel_code, {GAP_W{1'b0}}, n_ft, n_se, n_ct, 1'b0,
                       n_wr, fsr[0], 1'b1};
            far_va <= n_far;
        end
    end

    // Tag-access register loaded on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_acc <= '0;
        end else if (req_vld && n_tag_we) begin
            tag_acc <= {va_eff[VA_W-1:PAGE_W], {PAGE_W{1'b0}}} |
                       VA_W'(lk_ctx);
        end
    end

    assign fault_code = code_q;
endmodule

// File: rtl/dxc_chk.sv
// Checker: temporal properties on the result pulses and register updates.
module dxc_chk #(
    parameter int VA_W  = 64,
    parameter int FSR_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic             done,
    input logic             fault,
    input logic [2:0]       fault_code,
    input logic             uncache,
    input logic [FSR_W-1:0] fsr,
    input logic [VA_W-1:0]  tag_acc
);
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> (done ^ fault)); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !(done || fault)); // R2
    AST_STICKY_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (fsr != $past(fsr) && $past(fsr[0])) |-> fsr[1]); // R11
    AST_FSR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (fsr != $past(fsr)) |-> (fsr[0] && fault)); // R11
    AST_MISS_KEEPS_FSR: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && (fault_code == 3'd4 || fault_code == 3'd5)) |-> $stable(fsr)); // R8
    AST_TAG_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_acc != $past(tag_acc)) |-> (fault && (fault_code == 3'd4 || fault_code == 3'd5))); // R8
    AST_UC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        uncache |-> done); // R9
endmodule

bind dxc_top dxc_chk #(.VA_W(VA_W), .FSR_W(FSR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .uncache    (uncache),
    .fsr        (fsr),
    .tag_acc    (tag_acc)
);

// File: tb/tb_dxc_top.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random requests against a model.
module tb_dxc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [63:0] va = '0;
    logic        wr = 1'b0;
    logic [7:0]  code = '0;
    logic s_impl = 0, s_unp = 0, s_hyo = 0, s_sec = 0, s_blk = 0, s_nf = 0;
    logic s_real = 0, s_aiu = 0, s_mmu = 0, s_scr = 0;
    logic tl = 0, prv = 0, hyp = 0, am = 0, den = 0;
    logic [12:0] cpri = '0, csec = '0;
    logic        hit = 0, pw = 0, pnf = 0, pse = 0, ppv = 0;
    logic [39:0] ppage = '0, omask = '0;
    logic [12:0] lk_ctx;
    logic        lk_real, done, fault, uncache;
    logic [2:0]  fault_code;
    logic [39:0] pa;
    logic [23:0] fsr;
    logic [63:0] far_va, tag_acc;

    int checks = 0;
    int errors = 0;
    logic [23:0] m_fsr = '0;
    logic [63:0] m_far = '0, m_tag = '0;
    logic        e_done, e_fault, e_uc, e_real;
    logic [2:0]  e_code;
    logic [39:0] e_pa;
    logic [12:0] e_ctx;

    always #2.5 clk = ~clk;

    dxc_top dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_va(va), .req_wr(wr),
        .sel_code(code), .sel_implicit(s_impl), .sel_unpriv(s_unp),
        .sel_hyponly(s_hyo), .sel_second(s_sec), .sel_block(s_blk),
        .sel_nofault(s_nf), .sel_real(s_real), .sel_asuser(s_aiu),
        .sel_mmureg(s_mmu), .sel_scratch(s_scr), .st_tl_nz(tl), .st_priv(prv),
        .st_hyp(hyp), .st_amask(am), .st_dmmu_en(den), .ctx_pri(cpri),
        .ctx_sec(csec), .tlb_hit(hit), .tlb_ppage(ppage), .tlb_off_mask(omask),
        .tlb_writable(pw), .tlb_nofault(pnf), .tlb_side(pse), .tlb_priv(ppv),
        .lk_ctx(lk_ctx), .lk_real(lk_real), .done(done), .fault(fault),
        .fault_code(fault_code), .pa(pa), .uncache(uncache), .fsr(fsr),
        .far_va(far_va), .tag_acc(tag_acc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model from the requirements; updates model registers.
    task automatic model(output string tagr);
        logic [1:0]  ct;
        logic [63:0] vm;
        logic        selc, hole;
        logic [3:0]  ft;
        logic        se, w, fw, rl;
        logic [63:0] fa;
        e_done = 0; e_fault = 0; e_uc = 0; e_code = 0; e_pa = va[39:0];
        fw = 0; ft = 0; se = 0; w = wr; fa = va;
        ct = tl ? 2'd2 : (!s_impl && s_sec) ? 2'd1 : 2'd0;
        rl = (!den && !hyp) || (!s_impl && s_real);
        e_real = rl;
        e_ctx = (rl || tl) ? 13'd0 : (!s_impl && s_sec) ? csec : cpri;
        vm = am ? {32'd0, va[31:0]} : va;
        hole = !am && !(va[63:47] == 17'h0 || va[63:47] == 17'h1FFFF);
        selc = !s_impl && !hyp;
        tagr = "R10";
        if (selc && !prv && !s_unp) begin
            e_code = 1; ft = 4; ct = 2; fw = 1; tagr = "R4";
        end else if (selc && prv && s_hyo) begin
            e_code = 2; ft = 4; ct = 2; fw = 1; tagr = "R4";
        end else if (va[2:0] != 0 || (s_blk && va[5:0] != 0)) begin
            e_code = 3; ft = 1; w = 0; fw = 1; tagr = "R5";
        end else if (hole) begin
            e_code = 2; ft = 5; se = 1; w = 0; fw = 1; tagr = "R6";
        end else if (!s_impl && s_scr && (vm > 64'h38 || (vm >= 64'h20 && vm < 64'h30 && !hyp))) begin
            e_code = 2; ft = 4; se = 1; ct = 0; fw = 1; fa = vm; tagr = "R12";
        end else if (!s_impl && (s_mmu || s_scr)) begin
            e_done = 1; tagr = "R13";
        end else if (hyp && (s_impl || (!s_aiu && !s_real))) begin
            e_done = 1; tagr = "R7";
        end else if (!hit) begin
            e_code = rl ? 3'd4 : 3'd5; tagr = "R8";
            m_tag = {vm[63:13], 13'd0} | {51'd0, e_ctx};
        end else if (wr && !pw) begin
            e_code = 6; ft = 1; se = pse; fw = 1; fa = vm; tagr = "R9";
        end else if (pnf && !(s_nf && !s_impl)) begin
            e_code = 2; ft = 3; se = pse; fw = 1; fa = vm; tagr = "R9";
        end else if (!prv && ppv) begin
            e_code = 2; ft = 2; se = pse; fw = 1; fa = vm; tagr = "R9";
        end else begin
            e_done = 1; e_uc = pse;
            e_pa = (ppage & ~omask) | (va[39:0] & omask);
        end
        e_fault = !e_done;
        if (fw) begin
            m_fsr = {code, 5'd0, ft, se, ct, 1'b0, w, m_fsr[0], 1'b1};
            m_far = fa;
            if (tagr == "R10") tagr = "R11";
        end
    endtask

    task automatic run_req();
        string t;
        @(negedge clk);
        req_vld = 1;
        #1;
        model(t);
        chk({"R3 lk_ctx ", t}, 64'(lk_ctx), 64'(e_ctx));
        chk({"R3 lk_real ", t}, 64'(lk_real), 64'(e_real));
        @(negedge clk);
        req_vld = 0;
        chk({"R2 done ", t}, 64'(done), 64'(e_done));
        chk({"R2 fault ", t}, 64'(fault), 64'(e_fault));
        if (e_fault) chk({t, " code"}, 64'(fault_code), 64'(e_code));
        if (e_done) chk({t, " pa"}, 64'(pa), 64'(e_pa));
        chk({"R9 uncache ", t}, 64'(uncache), 64'(e_uc));
        chk({"R11 fsr ", t}, 64'(fsr), 64'(m_fsr));
        chk({"R11 far ", t}, far_va, m_far);
        chk({"R8 tag ", t}, tag_acc, m_tag);
    endtask

    // Benign base state: privileged, translated, implicit, hit, writable.
    task automatic base();
        va = 64'h0000_1234_5678_9AB8; wr = 0; code = 8'h80;
        s_impl = 1; s_unp = 1; s_hyo = 0; s_sec = 0; s_blk = 0; s_nf = 0;
        s_real = 0; s_aiu = 0; s_mmu = 0; s_scr = 0;
        tl = 0; prv = 1; hyp = 0; am = 0; den = 1;
        cpri = 13'h0155; csec = 13'h0AAA;
        hit = 1; pw = 1; pnf = 0; pse = 0; ppv = 0;
        ppage = 40'hAB_CDEF_0000; omask = 40'h1FFF;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        base();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done", 64'(done), 0);
        chk("R1 fault", 64'(fault), 0);
        chk("R1 fsr", 64'(fsr), 0);
        chk("R1 far", far_va, 0);
        chk("R1 tag", tag_acc, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R2 idle done", 64'(done), 0);
        chk("R2 idle fault", 64'(fault), 0);
        // Directed corners
        base(); run_req();                                   // R10 hit
        base(); s_impl = 0; s_sec = 1; run_req();            // R3 secondary
        base(); tl = 1; hit = 0; run_req();                  // R3 nucleus, R8 miss
        base(); den = 0; hit = 0; run_req();                 // R8 real miss
        base(); s_impl = 0; s_unp = 0; prv = 0; run_req();   // R4 priv action
        base(); s_impl = 0; s_hyo = 1; wr = 1; run_req();    // R4 hyp-only, R11 sticky
        base(); va[2:0] = 3'd4; wr = 1; run_req();           // R5
        base(); s_impl = 0; s_blk = 1; va[5:0] = 6'h08; run_req(); // R5 block
        base(); va = 64'h0000_8000_0000_0000; run_req();     // R6 hole
        base(); va = 64'h0000_8000_0000_0000; am = 1; hit = 0; run_req(); // R6 masked
        base(); hyp = 1; pw = 0; wr = 1; run_req();          // R7 bypass
        base(); wr = 1; pw = 0; pnf = 1; ppv = 1; prv = 0; run_req(); // R9 prot first
        base(); pnf = 1; ppv = 1; prv = 0; pse = 1; run_req(); // R9 no-fault second
        base(); ppv = 1; prv = 0; run_req();                 // R9 priv
        base(); pse = 1; omask = 40'hFF_FFFF; run_req();     // R9 uncache, R10
        base(); s_impl = 0; s_scr = 1; va = 64'h40; run_req(); // R12 above 0x38
        base(); s_impl = 0; s_scr = 1; va = 64'h28; run_req(); // R12 window
        base(); s_impl = 0; s_scr = 1; va = 64'h28; hyp = 1; run_req(); // R12 ok
        base(); s_impl = 0; s_mmu = 1; va = 64'h0000_7777_0000_0018; hit = 0; run_req(); // R13
        // Seeded random
        void'($urandom(32'd2024));
        for (int i = 0; i < 600; i++) begin
            int k;
            base();
            k = int'($urandom % 4);
            case (k)
                0: va = {16'h0, $urandom, 16'($urandom)} & ~64'h7;
                1: va = {16'hFFFF, $urandom, 16'($urandom)} & ~64'h7;
                2: va = {$urandom, $urandom};
                default: va = 64'($urandom % 13) << 3;
            endcase
            if ($urandom % 8 == 0) va[2:0] = 3'($urandom);
            wr = 1'($urandom); code = 8'($urandom);
            s_impl = 1'($urandom); s_unp = ($urandom % 4) != 0; s_hyo = ($urandom % 5) == 0;
            s_sec = 1'($urandom); s_blk = ($urandom % 5) == 0; s_nf = 1'($urandom);
            s_real = ($urandom % 4) == 0; s_aiu = ($urandom % 4) == 0;
            s_mmu = ($urandom % 8) == 0; s_scr = ($urandom % 6) == 0;
            tl = ($urandom % 4) == 0; prv = ($urandom % 4) != 0; hyp = ($urandom % 4) == 0;
            am = ($urandom % 4) == 0; den = ($urandom % 5) != 0;
            cpri = 13'($urandom); csec = 13'($urandom);
            hit = ($urandom % 4) != 0; pw = ($urandom % 4) != 0; pnf = ($urandom % 6) == 0;
            pse = 1'($urandom); ppv = ($urandom % 4) == 0;
            ppage = {8'($urandom), $urandom};
            omask = (40'd1 << (13 + 3 * ($urandom % 4))) - 40'd1;
            run_req();
        end
        @(negedge clk);
        chk("R2 final idle", 64'(done | fault), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule